// File: doc/BRIEF.md
# Glitch-Tolerant Gamepad Poll Voter

This block reads a serial shift-register gamepad once per request and returns one 8-bit button byte that a single corrupted read cannot spoil. A read can be damaged by a spurious extra clock reaching the pad. That extra clock deletes one bit, and every later bit then slides one place toward the start of the byte. To guard against this, the block polls twice. When the two bytes match, it returns that byte at once. When they differ, it polls a third time and returns the per-bit majority of the three bytes. A wrong bit in one poll therefore needs a matching wrong bit in another poll before it can flip a button. Every request ends within three polls.

Requests arrive on a valid/ready channel. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low during the power-on probe and for as long as a request is in flight. A `req_valid` that is raised while `req_ready` is low is dropped, not queued, so the requester has no need to hold it. The result leaves as a one-cycle strobe with no back-pressure, and the byte and flags stay stable until the next strobe.

After reset, the block clocks 16 bits out of the pad. If the last eight of them all read as pressed, it marks the pad as a standard type. On a standard pad, a corrupted read always shows the last button as pressed. An option makes the previous result stand in as one of the three votes, so each request then needs only two new polls.

Top module: `gp_poll_voter`

## Requirements
- R1: When the first two polls differ (option off), the block makes exactly one more poll. Each output bit is then the majority of that bit across the three polls, so a bit set in only one poll stays 0.
- R2: When the first two polls are equal (option off), the block returns that byte after exactly two polls and clears `btn_voted`.
- R3: A request never produces more than three latch pulses.
- R4: A poll is one `pad_latch` pulse of one cycle, followed by 8 `pad_clk` pulses. `pad_latch` and `pad_clk` are never high together. Each high phase of `pad_clk` lasts `cfg_div`+1 cycles, and so does each low phase.
- R5: `pad_data_n` is active-low and is inverted so that 1 means pressed. The bit sampled before the k-th clock pulse of a poll lands in bit k-1 of the byte. Bit 0 is A, then B, Select, Start, Up (bit 4), Down (bit 5), Left (bit 6) and Right (bit 7).
- R6: Out of reset the block runs one 16-pulse probe, and `req_ready` stays low until the probe ends. `pad_is_std` is then 1 exactly when probe bits 9 to 16 all read as pressed. During reset, `pad_latch`, `pad_clk`, `btn_valid` and `req_ready` are all 0.
- R7: With `cfg_reuse_prev`=1, the block makes exactly two polls. It returns the per-bit majority of the previous result, the first new poll and the second new poll. The previous result is 0 after reset.
- R8: `btn_valid` is high for exactly one cycle per request. `btn_byte` changes only on that cycle.
- R9: `btn_voted` reports whether the two new polls of the request disagreed.
- R10: `btn_conflict` is 1 exactly when the returned byte has Up and Down both set, or Left and Right both set.
- R11: A request raised while another is in flight has no effect: it adds no poll and no result strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request for a new button byte |
| req_ready | output | 1 | High when a request can be taken |
| cfg_reuse_prev | input | 1 | Use the previous result as one vote |
| cfg_div | input | 8 | Length of each pad clock phase, minus one |
| pad_latch | output | 1 | Latch pulse to the pad |
| pad_clk | output | 1 | Shift clock to the pad |
| pad_data_n | input | 1 | Serial data from the pad, active low |
| btn_valid | output | 1 | One-cycle strobe marking a new result |
| btn_byte | output | 8 | Voted button byte |
| btn_voted | output | 1 | The new polls disagreed on this request |
| btn_conflict | output | 1 | The result holds an opposite-direction pair |
| pad_is_std | output | 1 | Probe found a standard pad |

## Verification
If the poll slots or the sequencer state went wrong, the result strobe would carry a byte other than the majority or agreed value, or the pad pins would show a wrong count of latch or clock pulses. Either shows up within the same request. A fault in the shift engine shows up at once as a misordered or shifted byte, or as a clock phase of the wrong length, on the very next poll. A broken dropping of busy-time requests shows up as extra latch pulses or extra strobes within a few dozen cycles after the result.

// File: rtl/gpv_pkg.sv
package gpv_pkg;

  localparam int BIT_A      = 0;
  localparam int BIT_B      = 1;
  localparam int BIT_SELECT = 2;
  localparam int BIT_START  = 3;
  localparam int BIT_UP     = 4;
  localparam int BIT_DOWN   = 5;
  localparam int BIT_LEFT   = 6;
  localparam int BIT_RIGHT  = 7;

  localparam int MAX_POLLS  = 3;

  typedef enum logic [1:0] {
    SH_IDLE,
    SH_LATCH,
    SH_LOW,
    SH_HIGH
  } sh_state_t;

  typedef enum logic [2:0] {
    ST_PROBE_GO,
    ST_PROBE_WAIT,
    ST_IDLE,
    ST_POLL_GO,
    ST_POLL_WAIT,
    ST_EMIT
  } seq_state_t;

endpackage

// File: rtl/gpv_shifter.sv
module gpv_shifter
  import gpv_pkg::*;
#(
  parameter int MAX_BITS = 16,
  parameter int DIV_W    = 8,
  localparam int CNT_W   = $clog2(MAX_BITS + 1),
  localparam int IDX_W   = $clog2(MAX_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [CNT_W-1:0]    nbits_i,
  input  logic [DIV_W-1:0]    div_i,
  input  logic                pad_data_n_i,
  output logic                pad_latch_o,
  output logic                pad_clk_o,
  output logic                busy_o,
  output logic                done_o,
  output logic [MAX_BITS-1:0] word_o
);

  sh_state_t        st;
  logic [CNT_W-1:0] nbits_q;
  logic [CNT_W-1:0] bit_q;
  logic [DIV_W-1:0] div_cnt;

  assign busy_o = (st != SH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= SH_IDLE;
      nbits_q     <= '0;
      bit_q       <= '0;
      div_cnt     <= '0;
      pad_latch_o <= 1'b0;
      pad_clk_o   <= 1'b0;
      done_o      <= 1'b0;
      word_o      <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (st)
        SH_IDLE: begin
          if (start_i) begin
            st          <= SH_LATCH;
            pad_latch_o <= 1'b1;
            nbits_q     <= nbits_i;
            bit_q       <= '0;
            word_o      <= '0;
          end
        end
        SH_LATCH: begin
          pad_latch_o <= 1'b0;
          div_cnt     <= '0;
          st          <= SH_LOW;
        end
        SH_LOW: begin
          if (div_cnt == div_i) begin
            word_o[bit_q[IDX_W-1:0]] <= ~pad_data_n_i;
            pad_clk_o <= 1'b1;
            div_cnt   <= '0;
            st        <= SH_HIGH;
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        SH_HIGH: begin
          if (div_cnt == div_i) begin
            pad_clk_o <= 1'b0;
            div_cnt   <= '0;
            if (bit_q == nbits_q - CNT_W'(1)) begin
              st     <= SH_IDLE;
              done_o <= 1'b1;
            end else begin
              bit_q <= bit_q + 1'b1;
              st    <= SH_LOW;
            end
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        default: st <= SH_IDLE;
      endcase
    end
  end

  // R4: the latch pulse lasts a single cycle
  p_latch_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pad_latch_o |=> !pad_latch_o);

  // R4: latch and shift clock never overlap
  p_latch_clk_apart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(pad_latch_o && pad_clk_o));

  // R4: a finished poll leaves both pad pins low
  p_done_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!pad_clk_o && !pad_latch_o));

endmodule

// File: rtl/gpv_vote.sv
module gpv_vote
  import gpv_pkg::*;
#(
  parameter int BTN_W = 8
) (
  input  logic [BTN_W-1:0] a_i,
  input  logic [BTN_W-1:0] b_i,
  input  logic [BTN_W-1:0] c_i,
  input  logic             use_maj_i,
  output logic [BTN_W-1:0] res_o,
  output logic             conflict_o
);

  logic [BTN_W-1:0] maj;

  for (genvar i = 0; i < BTN_W; i++) begin : g_bit
    assign maj[i] = (a_i[i] & (b_i[i] | c_i[i])) | (b_i[i] & c_i[i]);
  end

  assign res_o      = use_maj_i ? maj : a_i;
  assign conflict_o = (res_o[BIT_UP] & res_o[BIT_DOWN]) |
                      (res_o[BIT_LEFT] & res_o[BIT_RIGHT]);

  // R1: a pair of equal votes always decides the majority
  always_comb begin
    if (a_i == c_i) begin
      p_pair_wins_r1: assert (maj == a_i);
    end
  end

endmodule

// File: rtl/gpv_seq.sv
module gpv_seq
  import gpv_pkg::*;
#(
  parameter int BTN_W   = 8,
  parameter int PROBE_W = 16,
  parameter int CNT_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic               cfg_reuse_i,
  output logic               sh_start_o,
  output logic [CNT_W-1:0]   sh_nbits_o,
  input  logic               sh_busy_i,
  input  logic               sh_done_i,
  input  logic [PROBE_W-1:0] sh_word_i,
  output logic [BTN_W-1:0]   va_o,
  output logic [BTN_W-1:0]   vb_o,
  output logic [BTN_W-1:0]   vc_o,
  output logic               use_maj_o,
  input  logic [BTN_W-1:0]   vres_i,
  input  logic               vconf_i,
  output logic               out_valid_o,
  output logic [BTN_W-1:0]   out_buttons_o,
  output logic               out_voted_o,
  output logic               out_conflict_o,
  output logic               std_pad_o
);

  seq_state_t       st;
  logic [1:0]       slot_q;
  logic [1:0]       poll_cnt;
  logic             reuse_q;
  logic             voted_q;
  logic [BTN_W-1:0] prev_q;
  logic [BTN_W-1:0] word8;

  assign word8       = sh_word_i[BTN_W-1:0];
  assign req_ready_o = (st == ST_IDLE);
  assign sh_start_o  = (st == ST_PROBE_GO) || (st == ST_POLL_GO);
  assign sh_nbits_o  = (st == ST_PROBE_GO) ? CNT_W'(PROBE_W) : CNT_W'(BTN_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st             <= ST_PROBE_GO;
      slot_q         <= '0;
      poll_cnt       <= '0;
      reuse_q        <= 1'b0;
      voted_q        <= 1'b0;
      prev_q         <= '0;
      va_o           <= '0;
      vb_o           <= '0;
      vc_o           <= '0;
      use_maj_o      <= 1'b0;
      out_valid_o    <= 1'b0;
      out_buttons_o  <= '0;
      out_voted_o    <= 1'b0;
      out_conflict_o <= 1'b0;
      std_pad_o      <= 1'b0;
    end else begin
      out_valid_o <= 1'b0;
      unique case (st)
        ST_PROBE_GO: st <= ST_PROBE_WAIT;
        ST_PROBE_WAIT: begin
          if (sh_done_i) begin
            std_pad_o <= &sh_word_i[PROBE_W-1:BTN_W];
            st        <= ST_IDLE;
          end
        end
        ST_IDLE: begin
          if (req_valid_i) begin
            reuse_q   <= cfg_reuse_i;
            poll_cnt  <= '0;
            use_maj_o <= 1'b0;
            voted_q   <= 1'b0;
            if (cfg_reuse_i) begin
              va_o   <= prev_q;
              slot_q <= 2'd1;
            end else begin
              slot_q <= 2'd0;
            end
            st <= ST_POLL_GO;
          end
        end
        ST_POLL_GO: begin
          poll_cnt <= poll_cnt + 1'b1;
          st       <= ST_POLL_WAIT;
        end
        ST_POLL_WAIT: begin
          if (sh_done_i) begin
            unique case (slot_q)
              2'd0: begin
                va_o   <= word8;
                slot_q <= 2'd1;
                st     <= ST_POLL_GO;
              end
              2'd1: begin
                vb_o <= word8;
                if (!reuse_q && (word8 == va_o)) begin
                  st <= ST_EMIT;
                end else begin
                  slot_q <= 2'd2;
                  st     <= ST_POLL_GO;
                end
              end
              default: begin
                vc_o      <= word8;
                use_maj_o <= 1'b1;
                voted_q   <= reuse_q ? (vb_o != word8) : 1'b1;
                st        <= ST_EMIT;
              end
            endcase
          end
        end
        ST_EMIT: begin
          out_valid_o    <= 1'b1;
          out_buttons_o  <= vres_i;
          out_conflict_o <= vconf_i;
          out_voted_o    <= voted_q;
          prev_q         <= vres_i;
          st             <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3: no request starts a fourth poll
  p_poll_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_POLL_GO) |-> (poll_cnt < 2'(MAX_POLLS)));

  // R7: reuse mode starts at most two new polls
  p_reuse_two_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_POLL_GO && reuse_q) |-> (poll_cnt < 2'd2));

  // R2: an agreed result comes out after exactly two polls
  p_agree_two_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_EMIT && !use_maj_o) |-> (poll_cnt == 2'd2));

  // R1: a voted result without reuse took three polls
  p_vote_three_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_EMIT && use_maj_o && !reuse_q) |-> (poll_cnt == 2'd3));

  // R8: the result strobe lasts one cycle
  p_strobe_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |=> !out_valid_o);

  // R8: the byte moves only together with the strobe
  p_hold_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid_o |-> $stable(out_buttons_o));

  // R11: no request is taken while the shifter runs
  p_busy_not_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sh_busy_i |-> !req_ready_o);

endmodule

// File: rtl/gp_poll_voter.sv
module gp_poll_voter
  import gpv_pkg::*;
#(
  parameter int BTN_W   = 8,
  parameter int PROBE_W = 16,
  parameter int DIV_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             cfg_reuse_prev,
  input  logic [DIV_W-1:0] cfg_div,
  output logic             pad_latch,
  output logic             pad_clk,
  input  logic             pad_data_n,
  output logic             btn_valid,
  output logic [BTN_W-1:0] btn_byte,
  output logic             btn_voted,
  output logic             btn_conflict,
  output logic             pad_is_std
);

  localparam int CNT_W = $clog2(PROBE_W + 1);

  logic               sh_start;
  logic [CNT_W-1:0]   sh_nbits;
  logic               sh_busy;
  logic               sh_done;
  logic [PROBE_W-1:0] sh_word;
  logic [BTN_W-1:0]   va, vb, vc, vres;
  logic               use_maj;
  logic               vconf;

  gpv_shifter #(
    .MAX_BITS (PROBE_W),
    .DIV_W    (DIV_W)
  ) u_shifter (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (sh_start),
    .nbits_i      (sh_nbits),
    .div_i        (cfg_div),
    .pad_data_n_i (pad_data_n),
    .pad_latch_o  (pad_latch),
    .pad_clk_o    (pad_clk),
    .busy_o       (sh_busy),
    .done_o       (sh_done),
    .word_o       (sh_word)
  );

  gpv_vote #(
    .BTN_W (BTN_W)
  ) u_vote (
    .a_i        (va),
    .b_i        (vb),
    .c_i        (vc),
    .use_maj_i  (use_maj),
    .res_o      (vres),
    .conflict_o (vconf)
  );

  gpv_seq #(
    .BTN_W   (BTN_W),
    .PROBE_W (PROBE_W),
    .CNT_W   (CNT_W)
  ) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid_i    (req_valid),
    .req_ready_o    (req_ready),
    .cfg_reuse_i    (cfg_reuse_prev),
    .sh_start_o     (sh_start),
    .sh_nbits_o     (sh_nbits),
    .sh_busy_i      (sh_busy),
    .sh_done_i      (sh_done),
    .sh_word_i      (sh_word),
    .va_o           (va),
    .vb_o           (vb),
    .vc_o           (vc),
    .use_maj_o      (use_maj),
    .vres_i         (vres),
    .vconf_i        (vconf),
    .out_valid_o    (btn_valid),
    .out_buttons_o  (btn_byte),
    .out_voted_o    (btn_voted),
    .out_conflict_o (btn_conflict),
    .std_pad_o      (pad_is_std)
  );

endmodule

// File: tb/gp_poll_voter_bench.sv
module gp_poll_voter_bench;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, req_valid, req_ready, cfg_reuse_prev;
  logic [7:0] cfg_div;
  logic       pad_latch, pad_clk, pad_data_n;
  logic       btn_valid, btn_voted, btn_conflict, pad_is_std;
  logic [7:0] btn_byte;

  gp_poll_voter u_gp_poll_voter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .cfg_reuse_prev(cfg_reuse_prev), .cfg_div(cfg_div),
    .pad_latch(pad_latch), .pad_clk(pad_clk), .pad_data_n(pad_data_n),
    .btn_valid(btn_valid), .btn_byte(btn_byte), .btn_voted(btn_voted),
    .btn_conflict(btn_conflict), .pad_is_std(pad_is_std)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  // pad model: each latch loads the next queued byte
  logic [7:0] pad_bytes [3];
  logic [7:0] pad_sr = 8'h00;
  logic       pad_fill = 1'b0;
  int pad_idx = 0, pad_shift = 8, latch_cnt = 0, clk_cnt = 0;
  int hi_run = 0, last_hi = 0;
  logic [7:0] prev_model = 8'h00;

  always @(posedge pad_latch) begin
    pad_sr    = pad_bytes[(pad_idx > 2) ? 2 : pad_idx];
    pad_idx   = pad_idx + 1;
    pad_shift = 0;
    latch_cnt = latch_cnt + 1;
  end

  always @(posedge pad_clk) begin
    pad_shift = pad_shift + 1;
    clk_cnt   = clk_cnt + 1;
  end

  assign pad_data_n = (pad_shift < 8) ? ~pad_sr[pad_shift[2:0]] : ~pad_fill;

  always @(negedge clk) begin
    if (pad_clk) hi_run = hi_run + 1;
    else begin
      if (hi_run != 0) last_hi = hi_run;
      hi_run = 0;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles == 190000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog actual=%0d expected=<190000", cycles);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks = n_checks + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] maj3(logic [7:0] a, logic [7:0] b, logic [7:0] c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // one deleted bit: later bits slide down, top filled by the line idle value
  function automatic logic [7:0] del_bit(logic [7:0] v, int k, logic fill);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      if (i < k) r[i] = v[i];
      else if (i < 7) r[i] = v[i+1];
      else r[i] = fill;
    end
    return r;
  endfunction

  function automatic logic conf(logic [7:0] v);
    return (v[4] & v[5]) | (v[6] & v[7]);
  endfunction

  task automatic issue();
    for (int t = 0; t < 5000 && !req_ready; t++) @(negedge clk);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_result(output bit got);
    got = 1'b0;
    for (int t = 0; t < 5000; t++) begin
      if (btn_valid) begin got = 1'b1; break; end
      @(negedge clk);
    end
    if (!got) chk(1'b0, "R8 no result strobe", 0, 1);
  endtask

  task automatic do_reset(input logic fill);
    rst_n = 1'b0; req_valid = 1'b0; pad_fill = fill;
    pad_bytes = '{8'h00, 8'h00, 8'h00};
    pad_idx = 0; latch_cnt = 0; clk_cnt = 0;
    repeat (3) @(negedge clk);
    chk(!btn_valid && !pad_latch && !pad_clk && !req_ready, "R6 reset state",
        {btn_valid, pad_latch, pad_clk, req_ready}, 0);
    rst_n = 1'b1; prev_model = 8'h00;
    @(negedge clk);
    chk(!req_ready, "R6 ready low during probe", req_ready, 0);
    for (int t = 0; t < 3000 && !req_ready; t++) @(negedge clk);
    chk(pad_is_std == fill, "R6 standard pad flag", pad_is_std, fill);
    chk(clk_cnt == 16 && latch_cnt == 1, "R6 probe length", clk_cnt, 16);
  endtask

  task automatic run_req(input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] c, input logic reuse);
    logic [7:0] exp;
    logic       exp_vote;
    int         exp_polls;
    bit         got;
    logic [7:0] held;
    if (reuse) begin
      exp = maj3(prev_model, a, b); exp_vote = (a != b); exp_polls = 2;
    end else if (a == b) begin
      exp = a; exp_vote = 1'b0; exp_polls = 2;
    end else begin
      exp = maj3(a, b, c); exp_vote = 1'b1; exp_polls = 3;
    end
    pad_bytes = '{a, b, c}; pad_idx = 0; latch_cnt = 0; clk_cnt = 0;
    cfg_reuse_prev = reuse;
    issue();
    wait_result(got);
    if (got) begin
      if (reuse) chk(btn_byte == exp, "R7 reuse majority", btn_byte, exp);
      else if (exp_vote) chk(btn_byte == exp, "R1 majority byte", btn_byte, exp);
      else chk(btn_byte == exp, "R2 agreed byte / R5 order", btn_byte, exp);
      chk(btn_voted == exp_vote, "R9 voted flag", btn_voted, exp_vote);
      chk(btn_conflict == conf(exp), "R10 conflict flag", btn_conflict, conf(exp));
      chk(latch_cnt == exp_polls, "R3 poll count", latch_cnt, exp_polls);
      chk(clk_cnt == 8 * exp_polls, "R4 clock pulses", clk_cnt, 8 * exp_polls);
      chk(last_hi == int'(cfg_div) + 1, "R4 high phase", last_hi, int'(cfg_div) + 1);
      held = btn_byte;
      @(negedge clk);
      chk(!btn_valid && btn_byte == held, "R8 strobe width / hold", btn_valid, 0);
      prev_model = exp;
    end
  endtask

  task automatic busy_test();
    bit got;
    int extra;
    pad_bytes = '{8'h01, 8'h02, 8'h01}; pad_idx = 0; latch_cnt = 0; clk_cnt = 0;
    cfg_reuse_prev = 1'b0;
    issue();
    for (int t = 0; t < 3000 && latch_cnt < 2; t++) @(negedge clk);
    chk(!req_ready, "R11 ready low while busy", req_ready, 0);
    req_valid = 1'b1;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    wait_result(got);
    if (got) chk(btn_byte == 8'h01, "R1 busy-run majority", btn_byte, 8'h01);
    prev_model = 8'h01;
    extra = 0;
    for (int t = 0; t < 120; t++) begin
      @(negedge clk);
      if (btn_valid) extra++;
    end
    chk(latch_cnt == 3 && extra == 0, "R11 stray request ignored", latch_cnt + extra, 3);
  endtask

  initial begin
    logic [7:0] a, b, c;
    void'($urandom(32'h5eed));
    cfg_div = 8'd1; cfg_reuse_prev = 1'b0; req_valid = 1'b0; rst_n = 1'b0;
    do_reset(1'b0);
    do_reset(1'b1);

    run_req(8'h01, 8'h01, 8'hFF, 1'b0);                       // R2 agreement, A bit
    run_req(8'h10, del_bit(8'h10, 0, 1'b1), 8'h10, 1'b0);     // R1 corrupted read loses
    run_req(8'h40, 8'h80, 8'hC0, 1'b0);                       // R10 left+right by voting
    run_req(8'h30, 8'h30, 8'h00, 1'b0);                       // R10 up+down agreed
    run_req(8'h81, 8'h81, 8'h00, 1'b0);                       // R5 first and last bit
    run_req(8'h01, 8'h02, 8'h00, 1'b1);                       // R7 reuse previous
    run_req(8'h05, 8'h05, 8'h00, 1'b1);                       // R7 reuse agreeing
    busy_test();                                               // R11
    cfg_div = 8'd0;
    run_req(8'h5A, 8'hA5, 8'h5A, 1'b0);                       // R4 fastest divider
    cfg_div = 8'd3;
    run_req(8'h3C, 8'h3C, 8'h00, 1'b0);

    for (int n = 0; n < 150; n++) begin
      cfg_div = 8'($urandom_range(0, 3));
      a = 8'($urandom);
      case ($urandom_range(0, 2))
        0: b = a;
        1: b = del_bit(a, $urandom_range(0, 7), 1'b1);
        default: b = 8'($urandom);
      endcase
      c = ($urandom_range(0, 1) == 0) ? a : 8'($urandom);
      run_req(a, b, c, ($urandom_range(0, 3) == 0));
    end

    summary();
    $finish;
  end

endmodule